// File: doc/BRIEF.md
# UART Receive Break Detector

This block sits beside a UART receiver. It watches the oversampled receive line and the strobes the receiver raises at the end of each frame. A break is a line held at space (low) for longer than a frame. The block declares one only when a frame ends with a framing error and the line then stays low for a full frame time, counted in oversample ticks. When it declares a break, it sets a sticky flag that software can read and clear.

From the moment a break is declared until the line is back at mark, the block drops every all-zero byte the receiver completes, so those bytes never reach the receive FIFO. All other bytes pass to the FIFO write port one clock after the receiver's frame-complete strobe. The frame length follows the receiver's character format: data bits, parity and stop bits.

Software reads the flag through a read strobe. It clears the flag by writing 0, and the clear works only if the flag was read as 1 first. If a new break arrives while the flag is already set, the flag stays at 1.

Top module: `uart_brk_guard`

## Requirements
- R1: After a synchronous reset, `brk_flag`, `fifo_wr` and `sw_rdata` are all 0.
- R2: A frame whose `frm_done` carries `frm_err`=1, followed by FT consecutive oversample ticks with `rxd_s`=0, sets `brk_flag` on the clock edge of the FT-th low tick. FT = OS_RATE × (1 start + (5 + `dbits_sel`) data + `par_en` + 1 + `stop2`) bits.
- R3: A high sample on any oversample tick before the FT-th low tick aborts the timing. Low ticks that follow without a new framing error do not set the flag.
- R4: A low line that is not preceded by a framing error never sets the flag, however long it lasts.
- R5: While a break is in progress, a completed frame whose byte is 0x00 causes no FIFO write. A non-zero byte is still written.
- R6: The break ends after two consecutive oversample ticks that sample high. A single high tick followed by a low tick does not end it. After the break ends, 0x00 bytes are written again.
- R7: Outside a break, every `frm_done` produces `fifo_wr`=1 on the next clock, with `fifo_data` equal to `rx_byte`. Framing-error frames are included.
- R8: A `sw_rd` pulse loads the current flag value into `sw_rdata` on the next clock edge. `sw_rdata` then holds that value.
- R9: `sw_wr` with `sw_wdata`=0 clears the flag only if a `sw_rd` has returned 1 since the flag last set. A write of 0 without that read, or any write of 1, leaves the flag unchanged.
- R10: A new break declared while the flag is set keeps the flag at 1. A break declared on the same edge as a valid clear also leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample enable; `rxd_s` is sampled when high |
| rxd_s | input | 1 | Synchronised receive line (1 = mark) |
| frm_done | input | 1 | Receiver frame-complete strobe |
| frm_err | input | 1 | Framing error for the frame in `frm_done` |
| rx_byte | input | DATA_W | Received byte, valid with `frm_done` |
| dbits_sel | input | 2 | Data bits minus 5 (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Two stop bits |
| sw_rd | input | 1 | Software read strobe for the flag |
| sw_wr | input | 1 | Software write strobe for the flag |
| sw_wdata | input | 1 | Value written to the flag (only 0 acts) |
| fifo_wr | output | 1 | Gated receive FIFO write strobe |
| fifo_data | output | DATA_W | Byte for the receive FIFO |
| brk_flag | output | 1 | Sticky break-detected flag |
| sw_rdata | output | 1 | Flag value captured by the last read |

## Verification
Each result has a fixed latency in clock edges:
- `fifo_wr` and `fifo_data` follow `frm_done` by one edge.
- `brk_flag` rises on the same edge that registers the FT-th low oversample tick.
- A clear takes effect on the edge that registers the write.
- `sw_rdata` updates one edge after `sw_rd`.
- A format change reaches the frame-length register after one edge.

The bench drives every input on the falling clock edge and holds each strobe for exactly one cycle. It then samples on the next falling edge, after the single register stage. It checks the boundary counts FT−1 and FT, along with randomly chosen counts around them, against a frame-length function computed in the bench.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    DET_IDLE  = 2'd0,
    DET_TIME  = 2'd1,
    DET_BREAK = 2'd2
  } det_st_e;

  localparam int MIN_DBITS = 5;
  localparam int MAX_BITS  = 1 + MIN_DBITS + 3 + 1 + 2;
endpackage

// File: rtl/brk_frame_len.sv
module brk_frame_len
  import brk_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       dbits_sel,
  input  logic             par_en,
  input  logic             stop2,
  output logic [CNT_W-1:0] frame_ticks
);
  localparam int BASE_BITS = 1 + MIN_DBITS + 1;

  logic [CNT_W-1:0] bits_c;

  always_comb begin
    bits_c = CNT_W'(BASE_BITS) + CNT_W'(dbits_sel) + CNT_W'(par_en) + CNT_W'(stop2);
  end

  always_ff @(posedge clk) begin
    if (rst) frame_ticks <= CNT_W'(BASE_BITS * OS_RATE);
    else     frame_ticks <= CNT_W'(bits_c * CNT_W'(OS_RATE));
  end
endmodule

// File: rtl/brk_detect.sv
module brk_detect
  import brk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             os_tick,
  input  logic             rxd_s,
  input  logic             frm_done,
  input  logic             frm_err,
  input  logic [CNT_W-1:0] frame_ticks,
  output logic             brk_set,
  output logic             in_break
);
  det_st_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hi_q;
  logic             last_low;

  always_comb begin
    last_low = os_tick && !rxd_s && (cnt_q == (frame_ticks - CNT_W'(1)));
    brk_set  = (state_q == DET_TIME) && last_low;
    in_break = (state_q == DET_BREAK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DET_IDLE;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
    end else begin
      case (state_q)
        DET_IDLE: begin
          hi_q <= 1'b0;
          if (frm_done && frm_err) begin
            state_q <= DET_TIME;
            cnt_q   <= '0;
          end
        end
        DET_TIME: begin
          if (os_tick) begin
            if (rxd_s)         state_q <= DET_IDLE;
            else if (last_low) state_q <= DET_BREAK;
            else               cnt_q   <= cnt_q + CNT_W'(1);
          end
        end
        DET_BREAK: begin
          if (os_tick) begin
            if (rxd_s) begin
              if (hi_q) state_q <= DET_IDLE;
              hi_q <= 1'b1;
            end else begin
              hi_q <= 1'b0;
            end
          end
        end
        default: state_q <= DET_IDLE;
      endcase
    end
  end

  // R2
  break_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DET_BREAK && $past(state_q) != DET_BREAK) |-> $past(state_q == DET_TIME));
  // R3
  abort_on_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DET_TIME && os_tick && rxd_s) |=> state_q == DET_IDLE);
  // R6
  mark_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DET_BREAK && os_tick && !hi_q) |=> state_q == DET_BREAK);
endmodule

// File: rtl/brk_flag_reg.sv
module brk_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic brk_set,
  input  logic sw_rd,
  input  logic sw_wr,
  input  logic sw_wdata,
  output logic brk_flag,
  output logic sw_rdata
);
  logic rd_seen_q;
  logic clr_ok;

  always_comb begin
    clr_ok = sw_wr && !sw_wdata && rd_seen_q && brk_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_flag  <= 1'b0;
      rd_seen_q <= 1'b0;
      sw_rdata  <= 1'b0;
    end else begin
      if (brk_set)     brk_flag <= 1'b1;
      else if (clr_ok) brk_flag <= 1'b0;

      if (clr_ok)                 rd_seen_q <= 1'b0;
      else if (sw_rd && brk_flag) rd_seen_q <= 1'b1;

      if (sw_rd) sw_rdata <= brk_flag;
    end
  end

  // R1
  flag_reset_chk: assert property (@(posedge clk) rst |=> !brk_flag && !sw_rdata);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    brk_set |=> brk_flag);
  // R9
  clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(brk_flag) |-> $past(sw_wr && !sw_wdata));
  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_flag) |-> $past(brk_set));
endmodule

// File: rtl/brk_fifo_gate.sv
module brk_fifo_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              in_break,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data
);
  logic drop_c;

  always_comb begin
    drop_c = in_break && (rx_byte == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
    end else begin
      fifo_wr <= frm_done && !drop_c;
      if (frm_done) fifo_data <= rx_byte;
    end
  end

  // R5
  zero_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_done && in_break && rx_byte == '0) |=> !fifo_wr);
  // R7
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_done && !in_break) |=> fifo_wr && fifo_data == $past(rx_byte));
endmodule

// File: rtl/uart_brk_guard.sv
module uart_brk_guard
  import brk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rxd_s,
  input  logic              frm_done,
  input  logic              frm_err,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [1:0]        dbits_sel,
  input  logic              par_en,
  input  logic              stop2,
  input  logic              sw_rd,
  input  logic              sw_wr,
  input  logic              sw_wdata,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              brk_flag,
  output logic              sw_rdata
);
  localparam int CNT_W = $clog2(OS_RATE * MAX_BITS + 1);

  logic [CNT_W-1:0] frame_ticks;
  logic             brk_set;
  logic             in_break;

  brk_frame_len #(.OS_RATE(OS_RATE), .CNT_W(CNT_W)) u_len (
    .clk(clk), .rst(rst), .dbits_sel(dbits_sel), .par_en(par_en),
    .stop2(stop2), .frame_ticks(frame_ticks)
  );

  brk_detect #(.CNT_W(CNT_W)) u_det (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd_s(rxd_s),
    .frm_done(frm_done), .frm_err(frm_err), .frame_ticks(frame_ticks),
    .brk_set(brk_set), .in_break(in_break)
  );

  brk_flag_reg u_flag (
    .clk(clk), .rst(rst), .brk_set(brk_set), .sw_rd(sw_rd), .sw_wr(sw_wr),
    .sw_wdata(sw_wdata), .brk_flag(brk_flag), .sw_rdata(sw_rdata)
  );

  brk_fifo_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst(rst), .frm_done(frm_done), .rx_byte(rx_byte),
    .in_break(in_break), .fifo_wr(fifo_wr), .fifo_data(fifo_data)
  );
endmodule

// File: tb/tb_uart_brk_guard.sv
module tb_uart_brk_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0, rxd_s = 1'b1, frm_done = 1'b0, frm_err = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [1:0] dbits_sel = 2'd3;
  logic       par_en = 1'b0, stop2 = 1'b0;
  logic       sw_rd = 1'b0, sw_wr = 1'b0, sw_wdata = 1'b1;
  logic       fifo_wr, brk_flag, sw_rdata;
  logic [7:0] fifo_data;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  uart_brk_guard dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd_s(rxd_s), .frm_done(frm_done),
    .frm_err(frm_err), .rx_byte(rx_byte), .dbits_sel(dbits_sel), .par_en(par_en),
    .stop2(stop2), .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .brk_flag(brk_flag), .sw_rdata(sw_rdata)
  );

  function automatic int ft_of(logic [1:0] ds, logic p, logic s2);
    return 16 * (1 + 5 + int'(ds) + int'(p) + 1 + int'(s2));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic v);
    @(negedge clk); os_tick = 1'b1; rxd_s = v;
    @(negedge clk); os_tick = 1'b0;
  endtask

  task automatic ticks(input logic v, input int n);
    for (int i = 0; i < n; i++) tick(v);
  endtask

  task automatic frame(input logic err, input logic [7:0] b, input bit exp_wr, input string req);
    @(negedge clk); frm_done = 1'b1; frm_err = err; rx_byte = b;
    @(negedge clk); frm_done = 1'b0; frm_err = 1'b0;
    chk(fifo_wr == exp_wr, req, int'(fifo_wr), int'(exp_wr));
    if (exp_wr) chk(fifo_data == b, req, int'(fifo_data), int'(b));
  endtask

  task automatic sw_read(input bit exp, input string req);
    @(negedge clk); sw_rd = 1'b1;
    @(negedge clk); sw_rd = 1'b0;
    chk(sw_rdata == exp, req, int'(sw_rdata), int'(exp));
  endtask

  task automatic sw_write(input logic v);
    @(negedge clk); sw_wr = 1'b1; sw_wdata = v;
    @(negedge clk); sw_wr = 1'b0; sw_wdata = 1'b1;
  endtask

  task automatic flag_is(input bit exp, input string req);
    chk(brk_flag == exp, req, int'(brk_flag), int'(exp));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  initial begin
    int ft;
    void'($urandom(32'h5eed_0b1c));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    flag_is(1'b0, "R1");
    chk(fifo_wr == 1'b0, "R1", int'(fifo_wr), 0);
    chk(sw_rdata == 1'b0, "R1", int'(sw_rdata), 0);
    ft = ft_of(dbits_sel, par_en, stop2);

    // R7 normal bytes, including zero outside a break
    frame(1'b0, 8'h5A, 1'b1, "R7");
    frame(1'b0, 8'h00, 1'b1, "R7");
    // R4 long low with no framing error
    ticks(1'b0, ft + 40);
    flag_is(1'b0, "R4");
    ticks(1'b1, 2);
    // R3 abort one tick short, then lows without new error
    frame(1'b1, 8'h00, 1'b1, "R7");
    ticks(1'b0, ft - 1);
    tick(1'b1);
    ticks(1'b0, ft + 5);
    flag_is(1'b0, "R3");
    ticks(1'b1, 2);
    // R2 exact boundary
    frame(1'b1, 8'h00, 1'b1, "R7");
    ticks(1'b0, ft - 1);
    flag_is(1'b0, "R2");
    tick(1'b0);
    flag_is(1'b1, "R2");
    // R5 suppression during break
    frame(1'b0, 8'h00, 1'b0, "R5");
    frame(1'b0, 8'h41, 1'b1, "R5");
    // R6 glitch filter
    tick(1'b1); tick(1'b0);
    frame(1'b0, 8'h00, 1'b0, "R6");
    tick(1'b1); tick(1'b1);
    frame(1'b0, 8'h00, 1'b1, "R6");
    // R9 clear protocol
    sw_write(1'b0);
    flag_is(1'b1, "R9");
    sw_read(1'b1, "R8");
    sw_write(1'b1);
    flag_is(1'b1, "R9");
    sw_write(1'b0);
    flag_is(1'b0, "R9");
    sw_read(1'b0, "R8");
    // R10 re-break while set, with simultaneous clear
    frame(1'b1, 8'h00, 1'b1, "R7");
    ticks(1'b0, ft);
    flag_is(1'b1, "R2");
    ticks(1'b1, 2);
    sw_read(1'b1, "R8");
    frame(1'b1, 8'h00, 1'b1, "R7");
    ticks(1'b0, ft - 1);
    @(negedge clk); os_tick = 1'b1; rxd_s = 1'b0; sw_wr = 1'b1; sw_wdata = 1'b0;
    @(negedge clk); os_tick = 1'b0; sw_wr = 1'b0; sw_wdata = 1'b1;
    flag_is(1'b1, "R10");
    ticks(1'b1, 2);
    sw_read(1'b1, "R8");
    sw_write(1'b0);
    flag_is(1'b0, "R9");

    // random format and low-run lengths around the boundary
    for (int it = 0; it < 40; it++) begin
      int n;
      bit exp_set;
      dbits_sel = 2'($urandom_range(0, 3));
      par_en = 1'($urandom_range(0, 1));
      stop2 = 1'($urandom_range(0, 1));
      repeat (2) @(negedge clk);
      ft = ft_of(dbits_sel, par_en, stop2);
      frame(1'b0, 8'($urandom_range(1, 255)), 1'b1, "R7");
      frame(1'b1, 8'h00, 1'b1, "R7");
      n = $urandom_range(ft - 3, ft + 2);
      exp_set = (n >= ft);
      ticks(1'b0, n);
      flag_is(exp_set, "R2");
      frame(1'b0, 8'h00, !exp_set, "R5");
      ticks(1'b1, 2);
      frame(1'b0, 8'h00, 1'b1, "R6");
      if (exp_set) begin
        sw_read(1'b1, "R8");
        sw_write(1'b0);
        flag_is(1'b0, "R9");
      end
    end
    finish_run();
  end
endmodule